// File: doc/BRIEF.md
# Watchdog Timer with Seconds/Minutes Unit

This block is a countdown watchdog that software sets up through a small set of byte-wide registers. Once the watchdog is switched on and given a nonzero count, it decrements that count once per time unit. The unit is either one second, taken directly from an external 1 Hz tick, or one minute, made by an internal divide-by-60 prescaler on the same tick. When the count runs out, the block latches an expired flag and emits a one-cycle fire pulse, which system logic can route to an interrupt or a reset.

Software keeps the watchdog from firing by writing the count again. It can also let keyboard or mouse activity pulses reload the count from the last value written. A self-clearing control bit fires the watchdog at once. The expired flag can be read back, and it is cleared by software.

Register addresses in hex: enable register 30, unit register F5, count register F6, control/status register F7. Reads are combinational on the addressed register.

Top module: `wdt_unit_timer`

## Requirements
- R1: After reset the watchdog is off, the unit is minutes, the count is 0, both activity reloads are disabled and the expired flag is 0. Reads return 30→00, F5→08, F6→00, F7→00.
- R2: Register 30 bit 0 switches the watchdog on. While it is 0 the count does not change, except when software writes it.
- R3: With F5 bit 3 at 0 (seconds), a running timer decrements by one on each 1 Hz tick.
- R4: With F5 bit 3 at 1 (minutes), a running timer decrements by one every 60 ticks. The tick prescaler restarts whenever the count is written or reloaded.
- R5: A count of 0 stops the timer. Writing F6 loads the count, restarts the countdown from the new value, and sets the value used for reloads.
- R6: When a decrement takes the count from 1 to 0, the expired flag sets, the count stays at 0, and the fire output is high for exactly one cycle.
- R7: With F7 bit 6 set, a keyboard pulse restores a running count to the last value written to F6. With bit 6 clear, the pulse has no effect.
- R8: With F7 bit 7 set, a mouse pulse restores a running count to the last value written to F6. With bit 7 clear, the pulse has no effect.
- R9: Writing 1 to F7 bit 5 sets the expired flag and pulses the fire output at once. Bit 5 always reads 0. This force takes priority over a clear written in the same cycle.
- R10: The expired flag clears when software writes 1 to F7 bit 4, or writes a nonzero value to F6.
- R11: F7 reads as {mouse enable (bit 7), keyboard enable (bit 6), 0 (bit 5), expired (bit 4), 0000}. F5 reads only bit 3. Register 30 reads only bit 0. F6 reads the current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| kbd_evt | input | 1 | One-cycle keyboard activity pulse |
| mouse_evt | input | 1 | One-cycle mouse activity pulse |
| wdt_fire | output | 1 | One-cycle timeout pulse |
| wdt_expired | output | 1 | Latched expired flag |

## Verification
On every cycle the assertions check these rules:
- a fire pulse always comes with the expired flag set, and a rising expired flag always comes with a fire pulse;
- an inactive timer holds its count, and a zero count stays at zero unless software writes it;
- the seconds unit decrements by exactly one per tick;
- a forced timeout fires on the next cycle.

Only the directed scenarios can show the rest:
- the exact 60-tick minute boundary and its restart after a count write;
- reload to the last written value, and pulses being ignored while their enable is clear;
- the read-back format of each register;
- the priority between force and clear.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned REG_AW = 8;
  localparam int unsigned REG_DW = 8;

  localparam logic [REG_AW-1:0] ADDR_ENABLE = 8'h30;
  localparam logic [REG_AW-1:0] ADDR_UNIT   = 8'hF5;
  localparam logic [REG_AW-1:0] ADDR_COUNT  = 8'hF6;
  localparam logic [REG_AW-1:0] ADDR_CTRL   = 8'hF7;

  localparam int unsigned BIT_ACTIVE = 0;
  localparam int unsigned BIT_UNIT   = 3;
  localparam int unsigned BIT_MOUSE  = 7;
  localparam int unsigned BIT_KBD    = 6;
  localparam int unsigned BIT_FORCE  = 5;
  localparam int unsigned BIT_STATUS = 4;

  typedef struct packed {
    logic active;
    logic unit_min;
    logic mouse_en;
    logic kbd_en;
  } wdt_cfg_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  input  logic [REG_DW-1:0] cnt_val,
  input  logic              expired,
  output wdt_cfg_t          cfg,
  output logic              cnt_wr,
  output logic [REG_DW-1:0] cnt_wdata,
  output logic              force_to,
  output logic              clr_stat,
  output logic [REG_DW-1:0] rdata
);
  wdt_cfg_t cfg_q, cfg_d;
  logic sel_en, sel_unit, sel_cnt, sel_ctrl;

  always_comb begin
    sel_en   = (addr == ADDR_ENABLE);
    sel_unit = (addr == ADDR_UNIT);
    sel_cnt  = (addr == ADDR_COUNT);
    sel_ctrl = (addr == ADDR_CTRL);
  end

  always_comb begin
    cfg_d = cfg_q;
    if (wr && sel_en)   cfg_d.active   = wdata[BIT_ACTIVE];
    if (wr && sel_unit) cfg_d.unit_min = wdata[BIT_UNIT];
    if (wr && sel_ctrl) begin
      cfg_d.mouse_en = wdata[BIT_MOUSE];
      cfg_d.kbd_en   = wdata[BIT_KBD];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.active   <= 1'b0;
      cfg_q.unit_min <= 1'b1;
      cfg_q.mouse_en <= 1'b0;
      cfg_q.kbd_en   <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  always_comb begin
    cfg       = cfg_q;
    cnt_wr    = wr && sel_cnt;
    cnt_wdata = wdata;
    force_to  = wr && sel_ctrl && wdata[BIT_FORCE];
    clr_stat  = wr && sel_ctrl && wdata[BIT_STATUS];
  end

  always_comb begin
    rdata = '0;
    if (sel_en)   rdata[BIT_ACTIVE] = cfg_q.active;
    if (sel_unit) rdata[BIT_UNIT]   = cfg_q.unit_min;
    if (sel_cnt)  rdata             = cnt_val;
    if (sel_ctrl) begin
      rdata[BIT_MOUSE]  = cfg_q.mouse_en;
      rdata[BIT_KBD]    = cfg_q.kbd_en;
      rdata[BIT_STATUS] = expired;
    end
  end
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int unsigned TICKS_PER_MIN = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic unit_min,
  input  logic run,
  input  logic restart,
  output logic step
);
  localparam int unsigned PW = (TICKS_PER_MIN > 1) ? $clog2(TICKS_PER_MIN) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICKS_PER_MIN - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic          pre_en;
  logic          wrap;

  always_comb begin
    wrap   = (pre_q == LAST);
    pre_en = restart || (run && unit_min && tick);
    pre_d  = pre_q;
    if (restart)   pre_d = '0;
    else if (wrap) pre_d = '0;
    else           pre_d = pre_q + 1'b1;
    step   = unit_min ? (tick && wrap) : tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (pre_en) pre_q <= pre_d;
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              cnt_wr,
  input  logic [REG_DW-1:0] cnt_wdata,
  input  logic              reload_req,
  input  logic              step,
  input  logic              force_to,
  input  logic              clr_stat,
  output logic [REG_DW-1:0] cnt,
  output logic              run,
  output logic              restart,
  output logic              expired,
  output logic              fire
);
  logic [REG_DW-1:0] cnt_q, cnt_d, rld_q, rld_d;
  logic stat_q, stat_d, fire_q, fire_d;
  logic run_c, do_reload, do_step, expire;

  always_comb begin
    run_c     = active && (cnt_q != '0);
    do_reload = !cnt_wr && run_c && reload_req;
    do_step   = !cnt_wr && run_c && !reload_req && step;
    expire    = do_step && (cnt_q == REG_DW'(1));

    cnt_d = cnt_q;
    rld_d = rld_q;
    if (cnt_wr) begin
      cnt_d = cnt_wdata;
      rld_d = cnt_wdata;
    end else if (do_reload) begin
      cnt_d = rld_q;
    end else if (do_step) begin
      cnt_d = cnt_q - 1'b1;
    end

    stat_d = stat_q;
    if (expire || force_to)                          stat_d = 1'b1;
    else if (clr_stat || (cnt_wr && cnt_wdata != '0)) stat_d = 1'b0;

    fire_d = expire || force_to;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rld_q  <= '0;
      stat_q <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      rld_q  <= rld_d;
      stat_q <= stat_d;
      fire_q <= fire_d;
    end
  end

  always_comb begin
    cnt     = cnt_q;
    run     = run_c;
    restart = cnt_wr || do_reload;
    expired = stat_q;
    fire    = fire_q;
  end
endmodule

// File: rtl/wdt_unit_timer.sv
module wdt_unit_timer
  import wdt_pkg::*;
#(
  parameter int unsigned TICKS_PER_MIN = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              tick_1hz,
  input  logic              kbd_evt,
  input  logic              mouse_evt,
  output logic              wdt_fire,
  output logic              wdt_expired
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  wdt_cfg_t          cfg;
  logic              cnt_wr, force_to, clr_stat, reload_req;
  logic [REG_DW-1:0] cnt_wdata, cnt;
  logic              run, restart, step, expired, fire;
  logic              cfg_active, cfg_unit;

  wdt_regs u_regs (
    .clk(clk), .rst_n(rst_n_s), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .cnt_val(cnt), .expired(expired), .cfg(cfg), .cnt_wr(cnt_wr),
    .cnt_wdata(cnt_wdata), .force_to(force_to), .clr_stat(clr_stat), .rdata(reg_rdata)
  );

  always_comb begin
    cfg_active = cfg.active;
    cfg_unit   = cfg.unit_min;
    reload_req = (kbd_evt && cfg.kbd_en) || (mouse_evt && cfg.mouse_en);
  end

  wdt_prescale #(.TICKS_PER_MIN(TICKS_PER_MIN)) u_pre (
    .clk(clk), .rst_n(rst_n_s), .tick(tick_1hz), .unit_min(cfg_unit),
    .run(run), .restart(restart), .step(step)
  );

  wdt_counter u_cnt (
    .clk(clk), .rst_n(rst_n_s), .active(cfg_active), .cnt_wr(cnt_wr),
    .cnt_wdata(cnt_wdata), .reload_req(reload_req), .step(step),
    .force_to(force_to), .clr_stat(clr_stat), .cnt(cnt), .run(run),
    .restart(restart), .expired(expired), .fire(fire)
  );

  assign wdt_fire    = fire;
  assign wdt_expired = expired;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       active,
  input logic       unit_min,
  input logic       tick,
  input logic [7:0] cnt,
  input logic       cnt_wr,
  input logic       reload_req,
  input logic       force_to,
  input logic       expired,
  input logic       fire
);
  // R6: a fire pulse always comes with the expired flag
  p_fire_with_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> expired);

  // R6: the expired flag never rises without a fire pulse
  p_rise_fires_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired) |-> fire);

  // R2: an inactive timer holds its count unless software writes it
  p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !cnt_wr) |=> $stable(cnt));

  // R5: a zero count stays at zero unless software writes it
  p_zero_stays_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 8'd0 && !cnt_wr) |=> cnt == 8'd0);

  // R3: the seconds unit decrements by exactly one per tick
  p_sec_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !unit_min && cnt > 8'd1 && tick && !cnt_wr && !reload_req)
      |=> cnt == $past(cnt) - 8'd1);

  // R9: a forced timeout fires on the next cycle
  p_force_fires_r9: assert property (@(posedge clk) disable iff (!rst_n)
    force_to |=> (fire && expired));
endmodule

bind wdt_unit_timer wdt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .active(cfg_active), .unit_min(cfg_unit),
  .tick(tick_1hz), .cnt(cnt), .cnt_wr(cnt_wr), .reload_req(reload_req),
  .force_to(force_to), .expired(wdt_expired), .fire(wdt_fire)
);

// File: tb/sim_wdt_unit_timer.sv
`timescale 1ns/1ps
module sim_wdt_unit_timer;
  logic       clk, rst_n, reg_wr, tick_1hz, kbd_evt, mouse_evt;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       wdt_fire, wdt_expired;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  wdt_unit_timer u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_1hz(tick_1hz),
    .kbd_evt(kbd_evt), .mouse_evt(mouse_evt), .wdt_fire(wdt_fire),
    .wdt_expired(wdt_expired)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(string tag, int actual, int expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, actual, expected);
    end
  endtask

  task automatic wr_reg(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(logic [7:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_1hz = 1'b1;
      @(negedge clk); tick_1hz = 1'b0;
    end
  endtask

  task automatic kbd_pulse();
    @(negedge clk); kbd_evt = 1'b1;
    @(negedge clk); kbd_evt = 1'b0;
  endtask

  task automatic mouse_pulse();
    @(negedge clk); mouse_evt = 1'b1;
    @(negedge clk); mouse_evt = 1'b0;
  endtask

  task automatic get_cnt(output logic [7:0] c);
    rd_reg(8'hF6, c);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd_reg(8'h30, v); check("R1 enable reg", v, 8'h00);
    rd_reg(8'hF5, v); check("R1 unit reg", v, 8'h08);
    rd_reg(8'hF6, v); check("R1 count reg", v, 8'h00);
    rd_reg(8'hF7, v); check("R1 ctrl reg", v, 8'h00);
    check("R1 fire", wdt_fire, 0);
    check("R1 expired", wdt_expired, 0);
  endtask

  task automatic t_inactive();
    logic [7:0] v;
    wr_reg(8'hF5, 8'h00);
    wr_reg(8'hF6, 8'd3);
    ticks(3);
    get_cnt(v); check("R2 inactive holds", v, 3);
    wr_reg(8'h30, 8'h01);
    ticks(1);
    get_cnt(v); check("R3 seconds step", v, 2);
    ticks(1);
    get_cnt(v); check("R3 seconds step 2", v, 1);
  endtask

  task automatic t_expire();
    logic [7:0] v;
    wr_reg(8'hF6, 8'd2);
    ticks(1);
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
    check("R6 fire pulse high", wdt_fire, 1);
    check("R6 expired set", wdt_expired, 1);
    @(negedge clk);
    check("R6 fire one cycle", wdt_fire, 0);
    ticks(3);
    get_cnt(v); check("R6 count stays zero", v, 0);
    check("R5 stopped no refire", wdt_fire, 0);
    rd_reg(8'hF7, v); check("R11 status bit", v, 8'h10);
  endtask

  task automatic t_clear();
    logic [7:0] v;
    wr_reg(8'hF7, 8'h10);
    check("R10 clear by bit4", wdt_expired, 0);
    wr_reg(8'hF7, 8'h20);
    check("R9 force fire", wdt_fire, 1);
    check("R9 force status", wdt_expired, 1);
    rd_reg(8'hF7, v); check("R9 bit5 reads 0", v, 8'h10);
    wr_reg(8'hF6, 8'd4);
    check("R10 clear by count", wdt_expired, 0);
    get_cnt(v); check("R5 count loaded", v, 4);
    wr_reg(8'hF6, 8'd0);
    ticks(2);
    get_cnt(v); check("R5 zero stops", v, 0);
    check("R5 zero no expiry", wdt_expired, 0);
  endtask

  task automatic t_reload();
    logic [7:0] v;
    wr_reg(8'hF7, 8'h40);
    wr_reg(8'hF6, 8'd5);
    ticks(2);
    kbd_pulse();
    get_cnt(v); check("R7 kbd reload", v, 5);
    ticks(1);
    mouse_pulse();
    get_cnt(v); check("R8 mouse ignored when off", v, 4);
    wr_reg(8'hF7, 8'h80);
    mouse_pulse();
    get_cnt(v); check("R8 mouse reload", v, 5);
    ticks(1);
    kbd_pulse();
    get_cnt(v); check("R7 kbd ignored when off", v, 4);
  endtask

  task automatic t_minutes();
    logic [7:0] v;
    wr_reg(8'hF7, 8'h00);
    wr_reg(8'hF5, 8'h08);
    wr_reg(8'hF6, 8'd2);
    ticks(59);
    get_cnt(v); check("R4 no step at 59", v, 2);
    ticks(1);
    get_cnt(v); check("R4 step at 60", v, 1);
    ticks(30);
    wr_reg(8'hF6, 8'd3);
    ticks(59);
    get_cnt(v); check("R4 restart after write", v, 3);
    ticks(1);
    get_cnt(v); check("R4 step after restart", v, 2);
  endtask

  task automatic t_readmap();
    logic [7:0] v;
    wr_reg(8'hF7, 8'hF0);
    rd_reg(8'hF7, v); check("R11 ctrl map force wins R9", v, 8'hD0);
    wr_reg(8'h30, 8'hFF);
    rd_reg(8'h30, v); check("R11 enable map", v, 8'h01);
    wr_reg(8'hF5, 8'hF7);
    rd_reg(8'hF5, v); check("R11 unit map", v, 8'h00);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 8'h00; reg_wdata = 8'h00;
    tick_1hz = 1'b0; kbd_evt = 1'b0; mouse_evt = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_inactive();
    t_expire();
    t_clear();
    t_reload();
    t_minutes();
    t_readmap();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule